// File: doc/BRIEF.md
# Embedded Operation Status Generator

This block builds the byte a host sees when it reads a flash-style memory while a built-in program or erase routine is running, and it drives the pull-down of an open-drain ready/busy line. A separate controller supplies level flags: routine running, erase kind, whole-array erase, the sector erase collection window, erase held in suspension, and time-limit fault. It also supplies the top bit of the word being programmed, a one-cycle pulse for each host read, and a flag that is high when the read address lies in a sector marked for erase. The block puts five status bits in place of array data and passes the other three array bits through.

Two status bits are toggle bits. They are stored in flip-flops that invert once for each read pulse, not on each clock, so a host that reads twice can tell a running routine from a finished one. The block also handles a program or erase that only targets protected sectors. On a one-cycle request it shows busy status for a fixed number of clock cycles and then returns to array data. The number of cycles depends on whether the request was a program or an erase.

Top module: `emb_status_gen`

## Requirements
- R1: After synchronous reset with all activity flags low, `dq_out` equals `arr_data` and `rb_pull_low` is 0. The first status read after reset shows bit 6 = 0 and bit 2 = 0.
- R2: Bit 7 shows the inverse of `prog_bit7` during a program and 0 during an erase. With no activity, the full byte equals `arr_data`.
- R3: While status is shown in busy mode, bit 6 inverts after every read pulse. It holds its value across cycles that have no read pulse.
- R4: Bit 5 equals `time_fault` in busy mode. Bit 6 keeps inverting on reads while the fault is present.
- R5: Bit 3 is 1 when an erase is running with the collection window closed. It is 0 while `erase_open` is high, and 0 during a program.
- R6: During a sector erase, bit 2 inverts only on reads with `rd_hit_erase` = 1. During an erase with `alg_chip` = 1, it inverts on every read. During a program it never inverts.
- R7: While `erase_held` is high, a read with `rd_hit_erase` = 1 shows bit 7 = 1, bit 5 = 0 and bit 3 = 1, with bit 2 inverting and bit 6 steady. A read with `rd_hit_erase` = 0 returns `arr_data`. `rb_pull_low` is 0 in this state.
- R8: `rb_pull_low` is 1 whenever `alg_busy`, `erase_open` or `time_fault` is high and `erase_held` is low. It is 0 once all of these are low.
- R9: A `prot_req` pulse in idle holds busy status for exactly PROT_PROG_CYC cycles when `prot_req_erase` = 0, or PROT_ERASE_CYC cycles when it is 1. During that time bit 7 follows R2. Afterwards the output is `arr_data`.
- R10: A `prot_req` is ignored while a routine, window, fault, suspension or earlier protected interval is active.
- R11: Bits 4, 1 and 0 of `dq_out` always equal the same bits of `arr_data`.
- R12: While `time_fault` is high during an erase with `alg_chip` = 1, bit 2 inverts only on reads with `rd_hit_erase` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alg_busy | input | 1 | Built-in routine running |
| alg_erase | input | 1 | Running routine is an erase (else program) |
| alg_chip | input | 1 | Erase covers the whole array |
| erase_open | input | 1 | Sector erase collection window open |
| erase_held | input | 1 | Erase suspended |
| time_fault | input | 1 | Time limit exceeded, held until reset command |
| prog_bit7 | input | 1 | Bit 7 of the word being programmed |
| rd_stb | input | 1 | One-cycle pulse per host read |
| rd_hit_erase | input | 1 | Read address lies in a sector selected for erase |
| prot_req | input | 1 | Pulse: operation aimed only at protected sectors |
| prot_req_erase | input | 1 | Kind of that operation (1 = erase) |
| arr_data | input | 8 | Array read data |
| dq_out | output | 8 | Byte returned to the host |
| rb_pull_low | output | 1 | 1 pulls the open-drain ready/busy line low |

## Verification
The bench builds the block with PROT_PROG_CYC = 4 and PROT_ERASE_CYC = 11. These are short enough that the exact length of both protected busy intervals can be counted cycle by cycle. Because the two values differ, the bench can also show that the request kind selects the length. With the default values, intervals of hundreds of cycles would give the same coverage, only more slowly.

// File: rtl/sts_pkg.sv
package sts_pkg;

    typedef enum logic [1:0] {
        SM_READ = 2'd0,
        SM_BUSY = 2'd1,
        SM_SUSP = 2'd2
    } sts_mode_e;

    typedef struct packed {
        logic poll;    // bit 7
        logic tog_a;   // bit 6
        logic fault;   // bit 5
        logic ers_run; // bit 3
        logic tog_b;   // bit 2
    } sts_bits_t;

    function automatic logic [7:0] sts_merge(input sts_bits_t s, input logic [7:0] arr);
        return {s.poll, s.tog_a, s.fault, arr[4], s.ers_run, s.tog_b, arr[1:0]};
    endfunction

    function automatic int unsigned sts_max(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sts_prot_timer.sv
module sts_prot_timer #(
    parameter int unsigned PROG_CYC  = 50,
    parameter int unsigned ERASE_CYC = 250
) (
    input  logic clk,
    input  logic rst,
    input  logic req,
    input  logic req_erase,
    input  logic blocked,
    output logic active,
    output logic kind_erase
);
    import sts_pkg::*;

    localparam int unsigned TOPV = sts_max(PROG_CYC, ERASE_CYC);
    localparam int unsigned CW   = $clog2(TOPV + 1);

    logic [CW-1:0] cnt;
    logic          kind_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt    <= '0;
            kind_q <= 1'b0;
        end else if (req && !blocked && (cnt == '0)) begin
            cnt    <= req_erase ? CW'(ERASE_CYC) : CW'(PROG_CYC);
            kind_q <= req_erase;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign active     = (cnt != '0);
    assign kind_erase = kind_q;
endmodule

// File: rtl/sts_toggle.sv
module sts_toggle (
    input  logic clk,
    input  logic rst,
    input  logic adv_a,
    input  logic adv_b,
    output logic tog_a,
    output logic tog_b
);
    always_ff @(posedge clk) begin
        if (rst) begin
            tog_a <= 1'b0;
            tog_b <= 1'b0;
        end else begin
            if (adv_a) tog_a <= ~tog_a;
            if (adv_b) tog_b <= ~tog_b;
        end
    end
endmodule

// File: rtl/sts_mode_dec.sv
module sts_mode_dec
    import sts_pkg::*;
(
    input  logic      alg_busy,
    input  logic      alg_erase,
    input  logic      alg_chip,
    input  logic      erase_open,
    input  logic      erase_held,
    input  logic      time_fault,
    input  logic      prog_bit7,
    input  logic      rd_stb,
    input  logic      rd_hit_erase,
    input  logic      prot_active,
    input  logic      prot_erase,
    input  logic      tog_a,
    input  logic      tog_b,
    output sts_mode_e mode,
    output logic      show,
    output sts_bits_t bits,
    output logic      adv_a,
    output logic      adv_b
);
    logic busy_any;
    logic eff_erase;
    logic b_sel;

    always_comb begin
        busy_any  = alg_busy | erase_open | time_fault | prot_active;
        eff_erase = prot_active ? prot_erase : (alg_erase | erase_open);

        if (erase_held)    mode = SM_SUSP;
        else if (busy_any) mode = SM_BUSY;
        else               mode = SM_READ;

        show  = (mode == SM_BUSY) | ((mode == SM_SUSP) & rd_hit_erase);
        bits  = '0;
        b_sel = 1'b0;

        unique case (mode)
            SM_BUSY: begin
                bits.poll    = eff_erase ? 1'b0 : ~prog_bit7;
                bits.tog_a   = tog_a;
                bits.fault   = time_fault;
                bits.ers_run = eff_erase & ~erase_open;
                bits.tog_b   = tog_b;
                b_sel        = eff_erase & ((alg_chip & ~time_fault) | rd_hit_erase);
            end
            SM_SUSP: begin
                bits.poll    = 1'b1;
                bits.tog_a   = tog_a;
                bits.fault   = 1'b0;
                bits.ers_run = 1'b1;
                bits.tog_b   = tog_b;
                b_sel        = rd_hit_erase;
            end
            default: begin
                bits  = '0;
                b_sel = 1'b0;
            end
        endcase

        adv_a = rd_stb & (mode == SM_BUSY);
        adv_b = rd_stb & b_sel;
    end
endmodule

// File: rtl/emb_status_gen.sv
module emb_status_gen
    import sts_pkg::*;
#(
    parameter int unsigned PROT_PROG_CYC  = 50,
    parameter int unsigned PROT_ERASE_CYC = 250
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       alg_busy,
    input  logic       alg_erase,
    input  logic       alg_chip,
    input  logic       erase_open,
    input  logic       erase_held,
    input  logic       time_fault,
    input  logic       prog_bit7,
    input  logic       rd_stb,
    input  logic       rd_hit_erase,
    input  logic       prot_req,
    input  logic       prot_req_erase,
    input  logic [7:0] arr_data,
    output logic [7:0] dq_out,
    output logic       rb_pull_low
);
    sts_mode_e mode;
    sts_bits_t bits;
    logic      show;
    logic      adv_a, adv_b;
    logic      tog_a, tog_b;
    logic      prot_active, prot_erase;
    logic      prot_blocked;

    assign prot_blocked = alg_busy | erase_open | erase_held | time_fault | prot_active;

    sts_prot_timer #(
        .PROG_CYC  (PROT_PROG_CYC),
        .ERASE_CYC (PROT_ERASE_CYC)
    ) u_ptim (
        .clk        (clk),
        .rst        (rst),
        .req        (prot_req),
        .req_erase  (prot_req_erase),
        .blocked    (prot_blocked),
        .active     (prot_active),
        .kind_erase (prot_erase)
    );

    sts_toggle u_tog (
        .clk   (clk),
        .rst   (rst),
        .adv_a (adv_a),
        .adv_b (adv_b),
        .tog_a (tog_a),
        .tog_b (tog_b)
    );

    sts_mode_dec u_dec (
        .alg_busy     (alg_busy),
        .alg_erase    (alg_erase),
        .alg_chip     (alg_chip),
        .erase_open   (erase_open),
        .erase_held   (erase_held),
        .time_fault   (time_fault),
        .prog_bit7    (prog_bit7),
        .rd_stb       (rd_stb),
        .rd_hit_erase (rd_hit_erase),
        .prot_active  (prot_active),
        .prot_erase   (prot_erase),
        .tog_a        (tog_a),
        .tog_b        (tog_b),
        .mode         (mode),
        .show         (show),
        .bits         (bits),
        .adv_a        (adv_a),
        .adv_b        (adv_b)
    );

    assign dq_out      = show ? sts_merge(bits, arr_data) : arr_data;
    assign rb_pull_low = (mode == SM_BUSY);
endmodule

// File: rtl/sts_chk.sv
module sts_chk (
    input logic       clk,
    input logic       rst,
    input logic       alg_busy,
    input logic       erase_open,
    input logic       erase_held,
    input logic       time_fault,
    input logic       rd_stb,
    input logic [7:0] arr_data,
    input logic [7:0] dq_out,
    input logic       rb_pull_low
);
    logic stat_busy;
    assign stat_busy = rb_pull_low && !erase_held;

    p_ready_low_r8: assert property (@(posedge clk) disable iff (rst)
        ((alg_busy || erase_open || time_fault) && !erase_held) |-> rb_pull_low);

    p_susp_release_r7: assert property (@(posedge clk) disable iff (rst)
        erase_held |-> !rb_pull_low);

    p_fault_bit_r4: assert property (@(posedge clk) disable iff (rst)
        (time_fault && !erase_held) |-> dq_out[5]);

    p_pass_bits_r11: assert property (@(posedge clk) disable iff (rst)
        1'b1 |-> (dq_out[4] == arr_data[4] && dq_out[1:0] == arr_data[1:0]));

    p_idle_pass_r2: assert property (@(posedge clk) disable iff (rst)
        (!rb_pull_low && !erase_held) |-> (dq_out == arr_data));

    p_tog_flip_r3: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && $past(rd_stb) && $past(stat_busy) && stat_busy)
            |-> (dq_out[6] != $past(dq_out[6])));

    p_tog_hold_r3: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && $past(!rd_stb) && $past(stat_busy) && stat_busy)
            |-> $stable(dq_out[6]));
endmodule

bind emb_status_gen sts_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .alg_busy    (alg_busy),
    .erase_open  (erase_open),
    .erase_held  (erase_held),
    .time_fault  (time_fault),
    .rd_stb      (rd_stb),
    .arr_data    (arr_data),
    .dq_out      (dq_out),
    .rb_pull_low (rb_pull_low)
);

// File: tb/sim_emb_status_gen.sv
module sim_emb_status_gen;
    localparam int CLK_P = 10;
    localparam int PPC   = 4;
    localparam int PEC   = 11;

    logic clk = 1'b0;
    logic rst, alg_busy, alg_erase, alg_chip, erase_open, erase_held, time_fault;
    logic prog_bit7, rd_stb, rd_hit_erase, prot_req, prot_req_erase;
    logic [7:0] arr_data;
    logic [7:0] dq_out;
    logic rb_pull_low;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #(CLK_P/2) clk = ~clk;

    emb_status_gen #(.PROT_PROG_CYC(PPC), .PROT_ERASE_CYC(PEC)) u0 (.*);

    // {busy,erase,chip,open,held,fault,pb7,hit}[40:33], rdy_low[32], arr[31:24], exp[23:16], mask[15:8], pad
    localparam int NV = 9;
    localparam logic [40:0] VEC [NV] = '{
        {8'b0000_0000, 1'b0, 8'h5A, 8'h5A, 8'hFF, 8'h00}, // R2 idle
        {8'b1000_0010, 1'b1, 8'h5A, 8'h12, 8'hBB, 8'h00}, // R2 R5 program b7=1
        {8'b1000_0000, 1'b1, 8'h5A, 8'h92, 8'hBB, 8'h00}, // R2 program b7=0
        {8'b0101_0000, 1'b1, 8'h5A, 8'h12, 8'hBB, 8'h00}, // R5 window open
        {8'b1100_0000, 1'b1, 8'h5A, 8'h1A, 8'hBB, 8'h00}, // R5 erase running
        {8'b1000_0110, 1'b1, 8'h5A, 8'h32, 8'hBB, 8'h00}, // R4 fault
        {8'b0100_1001, 1'b0, 8'h5A, 8'h9A, 8'hBB, 8'h00}, // R7 held, hit
        {8'b0100_1000, 1'b0, 8'h5A, 8'h5A, 8'hFF, 8'h00}, // R7 held, miss
        {8'b0000_0000, 1'b0, 8'hA5, 8'hA5, 8'hFF, 8'h00}  // R11 idle other data
    };

    task automatic chk(input bit ok, input string rq, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    task automatic set_in(input logic [7:0] f, input logic [7:0] arr);
        {alg_busy, alg_erase, alg_chip, erase_open, erase_held, time_fault, prog_bit7, rd_hit_erase} = f;
        arr_data = arr;
    endtask

    task automatic rd(output logic [7:0] v);
        @(negedge clk);
        rd_stb = 1'b1;
        #1 v = dq_out;
        @(negedge clk);
        rd_stb = 1'b0;
    endtask

    task automatic report;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=0 expected=1");
            report();
        end
    end

    initial begin
        logic [7:0] a, b, c;
        int cnt;
        rst = 1'b1; rd_stb = 0; prot_req = 0; prot_req_erase = 0;
        set_in(8'h00, 8'h3C);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        chk(dq_out == 8'h3C, "R1 reset data", dq_out, 8'h3C);
        chk(rb_pull_low == 1'b0, "R1 reset ready", rb_pull_low, 0);

        // R1: first status read after reset has both toggle bits 0
        @(negedge clk); set_in(8'b1100_0001, 8'h00);
        rd(a);
        chk(a[6] == 1'b0 && a[2] == 1'b0, "R1 toggle init", {a[6], a[2]}, 0);
        @(negedge clk); rst = 1'b1; @(negedge clk); rst = 1'b0; set_in(8'h00, 8'h00);

        // table walk
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            set_in(VEC[i][40:33], VEC[i][31:24]);
            #1;
            chk((dq_out & VEC[i][15:8]) == (VEC[i][23:16] & VEC[i][15:8]),
                $sformatf("R2/R4/R5/R7/R11 vec %0d", i), dq_out, VEC[i][23:16]);
            chk(rb_pull_low == VEC[i][32], $sformatf("R8 vec %0d ready", i), rb_pull_low, VEC[i][32]);
        end

        // R3: program, bit 6 flips per read, bit 2 fixed (R6)
        @(negedge clk); set_in(8'b1000_0001, 8'h00);
        rd(a); rd(b);
        chk(a[6] != b[6], "R3 flip", b[6], !a[6]);
        chk(a[2] == b[2], "R6 program no b2 flip", b[2], a[2]);
        repeat (3) @(negedge clk);
        #1 chk(dq_out[6] == b[6] ^ 1'b1, "R3 hold no read", dq_out[6], !b[6]);

        // R6: sector erase miss
        @(negedge clk); set_in(8'b1100_0000, 8'h00);
        rd(a); rd(b);
        chk(a[2] == b[2], "R6 sector miss", b[2], a[2]);
        // R6: sector erase hit
        @(negedge clk); set_in(8'b1100_0001, 8'h00);
        rd(a); rd(b);
        chk(a[2] != b[2], "R6 sector hit", b[2], !a[2]);
        // R6: chip erase miss toggles
        @(negedge clk); set_in(8'b1110_0000, 8'h00);
        rd(a); rd(b);
        chk(a[2] != b[2], "R6 chip any addr", b[2], !a[2]);
        // R12: chip erase with fault, miss fixed, hit toggles
        @(negedge clk); set_in(8'b1110_0100, 8'h00);
        rd(a); rd(b);
        chk(a[2] == b[2], "R12 fault miss", b[2], a[2]);
        chk(a[6] != b[6], "R4 b6 flips in fault", b[6], !a[6]);
        @(negedge clk); set_in(8'b1110_0101, 8'h00);
        rd(a); rd(b);
        chk(a[2] != b[2], "R12 fault hit", b[2], !a[2]);

        // R7: suspended hit, b6 steady, b2 toggles
        @(negedge clk); set_in(8'b0100_1001, 8'h00);
        rd(a); rd(b); rd(c);
        chk(a[6] == b[6] && b[6] == c[6], "R7 b6 steady", c[6], a[6]);
        chk(a[2] != b[2] && b[2] != c[2], "R7 b2 toggles", {a[2], b[2], c[2]}, 3'b010);

        // R9: protected program interval
        @(negedge clk); set_in(8'b0000_0010, 8'h00);
        prot_req = 1; prot_req_erase = 0;
        @(negedge clk); prot_req = 0;
        #1 chk(dq_out[7] == 1'b0, "R9 prog b7", dq_out[7], 0);
        cnt = 0;
        for (int k = 0; k < 40; k++) begin
            if (k > 0) #1;
            if (rb_pull_low) cnt++;
            @(negedge clk);
        end
        chk(cnt == PPC, "R9 prog len", cnt, PPC);
        #1 chk(dq_out == 8'h00, "R9 prog after", dq_out, 8'h00);

        // R9: protected erase interval
        @(negedge clk); set_in(8'h00, 8'hF0);
        prot_req = 1; prot_req_erase = 1;
        @(negedge clk); prot_req = 0;
        #1 chk(dq_out[7] == 1'b0 && dq_out[3] == 1'b1, "R9 erase bits", dq_out, 8'h08);
        cnt = 0;
        for (int k = 0; k < 40; k++) begin
            if (k > 0) #1;
            if (rb_pull_low) cnt++;
            @(negedge clk);
        end
        chk(cnt == PEC, "R9 erase len", cnt, PEC);

        // R10: request while busy ignored
        @(negedge clk); set_in(8'b1000_0000, 8'h77);
        prot_req = 1; prot_req_erase = 1;
        @(negedge clk); prot_req = 0; set_in(8'h00, 8'h77);
        #1;
        chk(rb_pull_low == 1'b0, "R10 ignored ready", rb_pull_low, 0);
        chk(dq_out == 8'h77, "R10 ignored data", dq_out, 8'h77);

        done = 1;
        report();
    end
endmodule